// File: doc/BRIEF.md
# Loop Task Sequencer

This block decides which data-processing task of a loop-structured algorithm runs next. Each task is driven by its own external state machine. When the active task signals completion, the sequencer reads a programmable table entry at an address built from the current task word plus one qualifying bit. That bit is the current loop's end status, gated by the completion of a backward (index-updating) task. The entry names the next task: its loop number, whether it is a forward or a backward task, and which forward task of that loop it is. In the cycle that follows, the sequencer raises the one-hot enable of that task's state machine and drives its loop number to the index unit. No idle cycles fall between tasks.

The table holds the only algorithm-specific state. A different loop nest, whether nested loops, sequential loops or a mix of both, runs after the table is reloaded through a plain write port while the sequencer is idle. A start pulse fetches the first task from a fixed entry. When the exit task completes, the sequencer stops and holds a done flag until the next start.

Top module: `loop_task_sequencer`

## Requirements
- R1: After reset, busy and done are 0, every bit of bwd_en and fwd_en is 0, and loop_addr is 0.
- R2: A start pulse while not busy makes the task stored at table address START (MSB set, bit 0 set, all other bits 0; 33 for the default widths) active in the next cycle, with busy 1 and done 0.
- R3: When task_done arrives with a backward task active, the next task comes from table address {current word, g}, where g = loop_end. The word is placed above bit 0, and g sits in bit 0.
- R4: When task_done arrives with a forward task active, bit 0 of the next address is 0 whatever loop_end is.
- R5: The enable of the next task is high in the cycle right after the task_done pulse. While busy, exactly one bit across bwd_en and fwd_en is high, and the enables and loop_addr hold until the next task_done.
- R6: A table word is {forward flag (MSB, 1 = forward), forward select (next FWD_W bits), loop number (LOOP_W LSBs)}. A backward word sets bwd_en[loop], a forward word sets fwd_en[select], and loop_addr carries the loop number in both cases.
- R7: The exit task is the backward task whose loop number is all ones. When it completes, the next cycle has busy 0, done 1 and all enables 0, and done holds until the next start.
- R8: Table writes take effect only while not busy, and a write made while busy leaves the table unchanged.
- R9: task_done and loop_end have no effect while not busy, and start has no effect while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin sequencing from the START entry |
| task_done | input | 1 | Completion pulse from the active task FSM |
| loop_end | input | 1 | Current loop has reached its final index |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | ADDR_W | Table write address |
| wr_data | input | WORD_W | Table write word |
| busy | output | 1 | A task is active |
| done | output | 1 | Exit task has completed |
| bwd_en | output | 2**LOOP_W | One-hot backward task enables |
| fwd_en | output | 2**FWD_W | One-hot forward task enables |
| loop_addr | output | LOOP_W | Loop number of the active task |

## Verification
The assertions assume that task_done comes only as a completion of the task being enabled, and that loop_end refers to the loop on loop_addr. They do not constrain either input while the sequencer is idle, since both are ignored there. The directed stimulus follows that contract: it walks a nested and a sequential loop and pulses loop_end only where a loop would end. It then adds stray pulses, starts while busy and writes while busy, which the requirements say must be ignored. A long random phase then drives all inputs freely against the behavioural model, because the block defines a result for any input combination.

// File: rtl/lts_pkg.sv
package lts_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } lts_state_t;
endpackage

// File: rtl/lts_table.sv
module lts_table #(
  parameter int WORD_W = 5,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Asynchronous read: the next task is known in the completion cycle.
  assign rdata = mem[raddr];
endmodule

// File: rtl/lts_addr.sv
module lts_addr #(
  parameter int WORD_W = 5,
  parameter int ADDR_W = WORD_W + 1
) (
  input  logic [WORD_W-1:0] cur_word,
  input  logic              from_start,
  input  logic              task_done,
  input  logic              loop_end,
  output logic [ADDR_W-1:0] raddr
);
  localparam logic [ADDR_W-1:0] START_ADDR =
    ADDR_W'((1 << (ADDR_W - 1)) | 1);

  logic is_fwd;
  logic gend;

  assign is_fwd = cur_word[WORD_W-1];
  assign gend   = task_done & loop_end & ~is_fwd;

  always_comb begin
    if (from_start) raddr = START_ADDR;
    else            raddr = {cur_word, gend};
  end
endmodule

// File: rtl/lts_decode.sv
module lts_decode #(
  parameter int LOOP_W = 3,
  parameter int FWD_W  = 1,
  localparam int WORD_W = 1 + FWD_W + LOOP_W,
  localparam int N_LOOP = 1 << LOOP_W,
  localparam int N_FWD  = 1 << FWD_W
) (
  input  logic [WORD_W-1:0] word,
  output logic [N_LOOP-1:0] bwd_vec,
  output logic [N_FWD-1:0]  fwd_vec,
  output logic [LOOP_W-1:0] loop_num
);
  logic              is_fwd;
  logic [FWD_W-1:0]  fsel;

  assign is_fwd   = word[WORD_W-1];
  assign fsel     = word[LOOP_W +: FWD_W];
  assign loop_num = word[LOOP_W-1:0];

  for (genvar i = 0; i < N_LOOP; i++) begin : g_bwd
    assign bwd_vec[i] = ~is_fwd && (loop_num == LOOP_W'(i));
  end

  for (genvar j = 0; j < N_FWD; j++) begin : g_fwd
    assign fwd_vec[j] = is_fwd && (fsel == FWD_W'(j));
  end
endmodule

// File: rtl/loop_task_sequencer.sv
module loop_task_sequencer #(
  parameter int LOOP_W = 3,
  parameter int FWD_W  = 1,
  localparam int WORD_W = 1 + FWD_W + LOOP_W,
  localparam int ADDR_W = WORD_W + 1,
  localparam int N_LOOP = 1 << LOOP_W,
  localparam int N_FWD  = 1 << FWD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              task_done,
  input  logic              loop_end,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              busy,
  output logic              done,
  output logic [N_LOOP-1:0] bwd_en,
  output logic [N_FWD-1:0]  fwd_en,
  output logic [LOOP_W-1:0] loop_addr
);
  import lts_pkg::*;

  lts_state_t        state;
  logic [WORD_W-1:0] cur_word;
  logic [ADDR_W-1:0] raddr;
  logic [WORD_W-1:0] rdata;
  logic [N_LOOP-1:0] nxt_bwd;
  logic [N_FWD-1:0]  nxt_fwd;
  logic [LOOP_W-1:0] nxt_loop;
  logic              running;
  logic              at_exit;

  assign running = (state == ST_RUN);
  assign at_exit = ~cur_word[WORD_W-1] & (&cur_word[LOOP_W-1:0]);

  lts_table #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_table (
    .clk   (clk),
    .we    (wr_en & ~running),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (raddr),
    .rdata (rdata)
  );

  lts_addr #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_addr (
    .cur_word   (cur_word),
    .from_start (~running),
    .task_done  (task_done),
    .loop_end   (loop_end),
    .raddr      (raddr)
  );

  lts_decode #(.LOOP_W(LOOP_W), .FWD_W(FWD_W)) u_dec (
    .word     (rdata),
    .bwd_vec  (nxt_bwd),
    .fwd_vec  (nxt_fwd),
    .loop_num (nxt_loop)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cur_word  <= '0;
      bwd_en    <= '0;
      fwd_en    <= '0;
      loop_addr <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          if (task_done) begin
            if (at_exit) begin
              state     <= ST_FIN;
              bwd_en    <= '0;
              fwd_en    <= '0;
              loop_addr <= '0;
            end else begin
              cur_word  <= rdata;
              bwd_en    <= nxt_bwd;
              fwd_en    <= nxt_fwd;
              loop_addr <= nxt_loop;
            end
          end
        end
        default: begin
          if (start) begin
            state     <= ST_RUN;
            cur_word  <= rdata;
            bwd_en    <= nxt_bwd;
            fwd_en    <= nxt_fwd;
            loop_addr <= nxt_loop;
          end
        end
      endcase
    end
  end

  assign busy = running;
  assign done = (state == ST_FIN);
endmodule

// File: rtl/lts_checker.sv
module lts_checker #(
  parameter int N_LOOP = 8,
  parameter int N_FWD  = 2,
  parameter int LOOP_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              task_done,
  input logic              busy,
  input logic              done,
  input logic [N_LOOP-1:0] bwd_en,
  input logic [N_FWD-1:0]  fwd_en,
  input logic [LOOP_W-1:0] loop_addr
);
  // R5: one task enabled while busy
  a_r5_one_task: assert property (@(posedge clk) disable iff (rst)
    busy |-> ($countones({bwd_en, fwd_en}) == 1));

  // R7: nothing enabled when idle or finished
  a_r7_quiet_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ({bwd_en, fwd_en} == '0));

  a_r7_done_excl: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R7: completion of the exit task ends sequencing
  a_r7_exit_stop: assert property (@(posedge clk) disable iff (rst)
    (busy && task_done && bwd_en[N_LOOP-1]) |=> (done && !busy));

  // R2: start from idle begins a run
  a_r2_start_run: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> (busy && !done));

  // R9: without start the sequencer stays idle
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !busy);

  // R5: outputs hold between completions
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && !task_done) |=> ($stable(bwd_en) && $stable(fwd_en) &&
                              $stable(loop_addr) && busy));
endmodule

bind loop_task_sequencer lts_checker #(
  .N_LOOP (N_LOOP),
  .N_FWD  (N_FWD),
  .LOOP_W (LOOP_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .task_done (task_done),
  .busy      (busy),
  .done      (done),
  .bwd_en    (bwd_en),
  .fwd_en    (fwd_en),
  .loop_addr (loop_addr)
);

// File: tb/loop_task_sequencer_tb_top.sv
module loop_task_sequencer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LOOP_W = 3;
  localparam int FWD_W  = 1;
  localparam int WORD_W = 1 + FWD_W + LOOP_W;
  localparam int ADDR_W = WORD_W + 1;
  localparam int N_LOOP = 1 << LOOP_W;
  localparam int N_FWD  = 1 << FWD_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int START  = (1 << (ADDR_W - 1)) | 1;
  localparam int EXITL  = N_LOOP - 1;

  logic clk = 1'b0;
  logic rst, start, task_done, loop_end, wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [WORD_W-1:0] wr_data;
  logic busy, done;
  logic [N_LOOP-1:0] bwd_en;
  logic [N_FWD-1:0]  fwd_en;
  logic [LOOP_W-1:0] loop_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_task_sequencer #(.LOOP_W(LOOP_W), .FWD_W(FWD_W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .task_done(task_done),
    .loop_end(loop_end), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .done(done), .bwd_en(bwd_en), .fwd_en(fwd_en),
    .loop_addr(loop_addr)
  );

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  // behavioural model
  int tab [DEPTH];
  bit m_busy, m_done;
  int m_cur;

  function automatic bit w_fwd(int w);  return ((w >> (WORD_W-1)) & 1) != 0; endfunction
  function automatic int w_sel(int w);  return (w >> LOOP_W) & (N_FWD-1);    endfunction
  function automatic int w_loop(int w); return w & (N_LOOP-1);               endfunction

  task automatic check(string tag);
    logic [N_LOOP-1:0] eb;
    logic [N_FWD-1:0]  ef;
    logic [LOOP_W-1:0] el;
    eb = '0; ef = '0; el = '0;
    if (m_busy) begin
      el = LOOP_W'(w_loop(m_cur));
      if (w_fwd(m_cur)) ef[w_sel(m_cur)] = 1'b1;
      else              eb[w_loop(m_cur)] = 1'b1;
    end
    n_run++;
    if ({busy, done, loop_addr, bwd_en, fwd_en} !== {m_busy, m_done, el, eb, ef}) begin
      n_fail++;
      $display("FAIL %s: got busy=%b done=%b loop=%0d bwd=%b fwd=%b, expected busy=%b done=%b loop=%0d bwd=%b fwd=%b",
               tag, busy, done, loop_addr, bwd_en, fwd_en, m_busy, m_done, el, eb, ef);
    end
  endtask

  task automatic cyc(input bit s, input bit d, input bit le, input bit w,
                     input int wa, input int wd, input string tag);
    bit was_busy;
    start = s; task_done = d; loop_end = le; wr_en = w;
    wr_addr = ADDR_W'(wa); wr_data = WORD_W'(wd);
    was_busy = m_busy;
    if (!m_busy && s) begin
      m_cur = tab[START]; m_busy = 1; m_done = 0;
    end else if (m_busy && d) begin
      if (!w_fwd(m_cur) && w_loop(m_cur) == EXITL) begin
        m_busy = 0; m_done = 1;
      end else begin
        m_cur = tab[m_cur * 2 + ((!w_fwd(m_cur) && le) ? 1 : 0)];
      end
    end
    if (!was_busy && w) tab[wa] = wd;
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  // words: {fwd, sel, loop}
  localparam int W_F1 = 17;  // forward sel0 loop1
  localparam int W_B1 = 1;   // backward loop1
  localparam int W_F2 = 26;  // forward sel1 loop2
  localparam int W_B2 = 2;   // backward loop2
  localparam int W_EX = 7;   // exit task
  localparam int W_B3 = 3;

  initial begin
    rst = 1; start = 0; task_done = 0; loop_end = 0; wr_en = 0;
    wr_addr = '0; wr_data = '0;
    m_busy = 0; m_done = 0; m_cur = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R1 reset state");

    for (int a = 0; a < DEPTH; a++) cyc(0, 0, 0, 1, a, W_B3, "R8 fill while idle");
    cyc(0, 0, 0, 1, START, W_F1, "R8 load");
    cyc(0, 0, 0, 1, W_F1*2,   W_B1, "R8 load");
    cyc(0, 0, 0, 1, W_F1*2+1, W_B2, "R8 load");
    cyc(0, 0, 0, 1, W_B1*2,   W_B1, "R8 load");
    cyc(0, 0, 0, 1, W_B1*2+1, W_F2, "R8 load");
    cyc(0, 0, 0, 1, W_F2*2,   W_B2, "R8 load");
    cyc(0, 0, 0, 1, W_F2*2+1, W_B1, "R8 load");
    cyc(0, 0, 0, 1, W_B2*2,   W_B2, "R8 load");
    cyc(0, 0, 0, 1, W_B2*2+1, W_EX, "R8 load");
    cyc(0, 1, 1, 0, 0, 0, "R9 task_done while idle ignored");

    cyc(1, 0, 0, 0, 0, 0, "R2 start fetches START entry");
    cyc(0, 0, 1, 0, 0, 0, "R5 hold without task_done");
    cyc(0, 1, 1, 0, 0, 0, "R4 forward completion ignores loop_end");
    cyc(0, 0, 0, 1, W_B1*2, W_F2, "R8 write while busy ignored");
    cyc(0, 1, 0, 0, 0, 0, "R3 loop_end low repeats loop");
    cyc(1, 0, 0, 0, 0, 0, "R9 start while busy ignored");
    cyc(0, 1, 0, 0, 0, 0, "R3 loop_end low again");
    cyc(0, 1, 1, 0, 0, 0, "R3 loop_end high leaves loop");
    cyc(0, 1, 1, 0, 0, 0, "R6 forward select 1 decode and R4");
    cyc(0, 1, 0, 0, 0, 0, "R5 back-to-back completions");
    cyc(0, 1, 1, 0, 0, 0, "R3 to exit task");
    cyc(0, 0, 0, 0, 0, 0, "R6 exit task enable");
    cyc(0, 1, 0, 0, 0, 0, "R7 exit completion");
    cyc(0, 1, 1, 0, 0, 0, "R7 done held, R9 pulses ignored");
    cyc(0, 0, 0, 0, 0, 0, "R7 done held");
    cyc(0, 0, 0, 1, START, W_EX, "R8 reload while done");
    cyc(1, 0, 0, 0, 0, 0, "R2 restart clears done");
    cyc(0, 1, 0, 0, 0, 0, "R7 immediate exit");

    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 8) == 0, ($urandom % 5) < 2, ($urandom % 3) == 0,
          ($urandom % 6) == 0, int'($urandom % DEPTH), int'($urandom % (1 << WORD_W)),
          "R5 R6 random traffic");
    end

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule